// File: doc/BRIEF.md
# Retention Voltage Sequencer

This block is the requesting side of a quiescence handshake for one processor power domain. When the domain reports it has no work (its activity line is low), the sequencer drops an active-low quiescence request. If the domain accepts, the sequencer switches a regulator select to the reduced retention voltage. If the domain refuses, the sequencer withdraws the request. It then waits for the refusal to clear and for a programmable back-off count before it tries again. Repeated refusals are retried one after another without limit.

When the domain raises its activity line during retention, the sequencer first selects the running voltage again. It keeps the request low until the regulator reports a stable supply, and only then releases the request. It then waits for the domain to withdraw its acceptance before returning to idle, from where it may enter retention again. If the supply does not become stable within a programmable number of cycles, a sticky error flag is raised, and the request is still held until stability arrives. Two counters record successful retention entries and refusals.

Top module: `ret_volt_seq`

## Requirements
- R1: After reset `req_n` is 1, `ret_sel` is 0, `volt_err` is 0 and both counters are 0.
- R2: In idle, with `dev_active` low, `req_n` falls on the next clock edge.
- R3: While requesting, a sampled `acc_n` low with `deny` low raises `ret_sel` on the next edge and increments `entry_cnt` by one.
- R4: While requesting, a sampled `deny` high raises `req_n` on the next edge and increments `deny_cnt`, even when `acc_n` is low in the same cycle. `ret_sel` is not raised in that case.
- R5: After a refusal, `req_n` stays high until `deny` is low and `backoff_cycles` further edges have passed since the refusal was taken; one idle cycle then precedes the new request. Back-to-back refusals are each counted.
- R6: In retention, a sampled `dev_active` high drops `ret_sel` on the next edge while `req_n` stays low.
- R7: After restoring, `req_n` rises only on the edge after `v_stable` is sampled high; while `v_stable` stays low, `req_n` stays low.
- R8: If `v_stable` stays low while restoring until the restore timer has counted `timeout_cycles` edges, `volt_err` rises and stays high until reset.
- R9: After releasing the request, the sequencer returns to idle once `acc_n` is sampled high. From idle it may request and enter retention again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dev_active | input | 1 | Domain has work; high asks to leave retention |
| acc_n | input | 1 | Active-low acceptance of quiescence |
| deny | input | 1 | Domain refuses quiescence |
| v_stable | input | 1 | Regulator reports running voltage stable |
| backoff_cycles | input | BO_W | Retry back-off after a refusal |
| timeout_cycles | input | TO_W | Restore stability timeout |
| req_n | output | 1 | Active-low quiescence request |
| ret_sel | output | 1 | High selects retention voltage |
| volt_err | output | 1 | Sticky restore timeout error |
| entry_cnt | output | CNT_W | Successful retention entries |
| deny_cnt | output | CNT_W | Refusals received |

## Verification
Acceptance and refusal can arrive in the same sampled cycle. The bench provokes this with a device mode that drops `acc_n` and raises `deny` together in answer to every request. The judgement is that only the refusal takes effect: `deny_cnt` advances, `entry_cnt` does not, and `ret_sel` never goes high during that window. A reference model checks the same outcome on every clock.

// File: rtl/ret_volt_seq.sv
module ret_volt_seq #(
  parameter int BO_W  = 8,
  parameter int TO_W  = 8,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dev_active,
  input  logic             acc_n,
  input  logic             deny,
  input  logic             v_stable,
  input  logic [BO_W-1:0]  backoff_cycles,
  input  logic [TO_W-1:0]  timeout_cycles,
  output logic             req_n,
  output logic             ret_sel,
  output logic             volt_err,
  output logic [CNT_W-1:0] entry_cnt,
  output logic [CNT_W-1:0] deny_cnt
);

  typedef enum logic [2:0] {
    S_RUN, S_REQ, S_RET, S_RESTORE, S_EXIT, S_DENIED
  } st_t;

  st_t             st;
  logic [BO_W-1:0] bo;
  logic [TO_W-1:0] tmr;

  assign req_n   = !(st == S_REQ || st == S_RET || st == S_RESTORE);
  assign ret_sel = (st == S_RET);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_RUN;
      bo        <= '0;
      tmr       <= '0;
      volt_err  <= 1'b0;
      entry_cnt <= '0;
      deny_cnt  <= '0;
    end else begin
      case (st)
        S_RUN:
          if (!dev_active) st <= S_REQ;
        S_REQ:
          if (deny) begin
            st       <= S_DENIED;
            bo       <= backoff_cycles;
            deny_cnt <= deny_cnt + 1'b1;
          end else if (!acc_n) begin
            st        <= S_RET;
            entry_cnt <= entry_cnt + 1'b1;
          end
        S_RET:
          if (dev_active) begin
            st  <= S_RESTORE;
            tmr <= '0;
          end
        S_RESTORE:
          if (v_stable) st <= S_EXIT;
          else if (tmr == timeout_cycles) volt_err <= 1'b1;
          else tmr <= tmr + 1'b1;
        S_EXIT:
          if (acc_n) st <= S_RUN;
        S_DENIED: begin
          if (bo != '0) bo <= bo - 1'b1;
          if (bo == '0 && !deny) st <= S_RUN;
        end
        default: st <= S_RUN;
      endcase
    end
  end

  p_req_on_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RUN && !dev_active) |=> !req_n);
  p_lower_after_accept_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ret_sel) |-> ($past(!acc_n) && $past(!deny)));
  p_deny_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_REQ && deny) |=> (req_n && !ret_sel));
  p_restore_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RET && dev_active) |=> (!ret_sel && !req_n));
  p_release_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RESTORE && !v_stable) |=> !req_n);
  p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    volt_err |=> volt_err);
  p_exit_wait_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_EXIT && !acc_n) |=> (req_n && st == S_EXIT));

endmodule

// File: tb/tb_ret_volt_seq.sv
module tb_ret_volt_seq;
  logic clk = 0;
  logic rst_n = 0;
  logic dev_active = 1, acc_n = 1, deny = 0, v_stable = 1;
  logic [7:0] backoff_cycles = 8'd3, timeout_cycles = 8'd10;
  logic req_n, ret_sel, volt_err;
  logic [7:0] entry_cnt, deny_cnt;

  int tests = 0, fails = 0;
  bit dev_deny_mode = 0, dev_both = 0;
  bit deny_window = 0, ret_in_window = 0;
  int cycles = 0;

  ret_volt_seq dut (.*);

  always #5 clk = ~clk;

  // behavioural reference: phase 0 idle,1 req,2 ret,3 restore,4 exit,5 refused
  int m_ph = 0, m_bo = 0, m_t = 0, m_ent = 0, m_den = 0;
  bit m_err = 0;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ph = 0; m_bo = 0; m_t = 0; m_ent = 0; m_den = 0; m_err = 0;
    end else begin
      if (m_ph == 0) begin
        if (!dev_active) m_ph = 1;
      end else if (m_ph == 1) begin
        if (deny) begin m_ph = 5; m_bo = backoff_cycles; m_den = (m_den + 1) % 256; end
        else if (!acc_n) begin m_ph = 2; m_ent = (m_ent + 1) % 256; end
      end else if (m_ph == 2) begin
        if (dev_active) begin m_ph = 3; m_t = 0; end
      end else if (m_ph == 3) begin
        if (v_stable) m_ph = 4;
        else if (m_t == timeout_cycles) m_err = 1;
        else m_t++;
      end else if (m_ph == 4) begin
        if (acc_n) m_ph = 0;
      end else begin
        if (m_bo == 0 && !deny) m_ph = 0;
        if (m_bo > 0) m_bo--;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison, then device response
  always @(negedge clk) begin
    if (rst_n) begin
      cycles++;
      chk(req_n == (m_ph >= 1 && m_ph <= 3) ? 1'b0 : 1'b1, "R2 req_n", req_n, (m_ph >= 1 && m_ph <= 3) ? 0 : 1);
      chk(ret_sel == (m_ph == 2), "R3 ret_sel", ret_sel, m_ph == 2);
      chk(volt_err == m_err, "R8 volt_err", volt_err, m_err);
      chk(entry_cnt == m_ent, "R3 entry_cnt", entry_cnt, m_ent);
      chk(deny_cnt == m_den, "R4 deny_cnt", deny_cnt, m_den);
      if (deny_window && ret_sel) ret_in_window = 1;
      if (!req_n) begin
        if (dev_deny_mode || dev_both) deny = 1;
        if (!dev_deny_mode || dev_both) acc_n = 0;
      end else begin
        deny = 0;
        acc_n = 1;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int d0, e0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(req_n && !ret_sel && !volt_err && entry_cnt == 0 && deny_cnt == 0, "R1 reset", req_n, 1);

    dev_active = 0;
    repeat (6) @(negedge clk);
    chk(ret_sel == 1, "R3 entered", ret_sel, 1);
    chk(entry_cnt == 1, "R3 count", entry_cnt, 1);

    v_stable = 0;
    dev_active = 1;
    repeat (2) @(negedge clk);
    chk(!ret_sel && !req_n, "R6 restore first", {ret_sel, req_n}, 0);
    repeat (2) @(negedge clk);
    chk(!req_n, "R7 hold while unstable", req_n, 0);
    v_stable = 1;
    repeat (5) @(negedge clk);
    chk(req_n == 1 && !volt_err, "R7 released", req_n, 1);

    dev_active = 0;
    repeat (8) @(negedge clk);
    chk(ret_sel == 1 && entry_cnt == 2, "R9 re-entry", entry_cnt, 2);
    dev_active = 1;
    repeat (8) @(negedge clk);
    chk(!ret_sel && req_n, "R9 exit", req_n, 1);

    dev_deny_mode = 1;
    deny_window = 1;
    d0 = deny_cnt; e0 = entry_cnt;
    dev_active = 0;
    repeat (4) @(negedge clk);
    chk(req_n == 1, "R5 backoff holds request", req_n, 1);
    repeat (40) @(negedge clk);
    chk(deny_cnt >= d0 + 3, "R5 repeated retries", deny_cnt, d0 + 3);
    chk(entry_cnt == e0, "R4 no entry on refusal", entry_cnt, e0);

    dev_both = 1;
    d0 = deny_cnt;
    repeat (30) @(negedge clk);
    chk(deny_cnt > d0 && entry_cnt == e0, "R4 deny beats accept", deny_cnt, d0 + 1);
    chk(!ret_in_window, "R4 no lowering while refused", ret_in_window, 0);
    dev_both = 0;
    dev_deny_mode = 0;
    repeat (3) @(negedge clk);
    deny_window = 0;
    repeat (20) @(negedge clk);
    chk(ret_sel == 1 && entry_cnt == e0 + 1, "R9 entry after retries", entry_cnt, e0 + 1);

    v_stable = 0;
    dev_active = 1;
    repeat (30) @(negedge clk);
    chk(volt_err == 1, "R8 timeout flagged", volt_err, 1);
    chk(req_n == 0, "R7 request held past timeout", req_n, 0);
    v_stable = 1;
    repeat (6) @(negedge clk);
    chk(req_n == 1 && volt_err == 1, "R8 error sticky", volt_err, 1);

    repeat (5) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule